// File: doc/BRIEF.md
# Configuration Bitstream Loader

The loader takes a configuration image from a host as 32-bit words and feeds it, in order, to downstream programmable devices over a simple valid/ready word stream. The host sees a small register window. It writes the expected image length in bytes while the block is idle, then sets the enable bit. After that it pushes words into a data port that is backed by a word FIFO. The block counts the bytes accepted downstream and stops when the count meets the programmed length.

One level-sensitive interrupt reports that a load has finished or has failed. It stays high until software writes the control register with enable cleared. In DMA mode the block raises a request line whenever the FIFO can take a half-FIFO burst and the queued data has not yet covered the programmed length. An external DMA engine can then pace the whole transfer with no CPU involvement. A control bit combined with enable drives a reset line to the downstream devices. The status register also shows the devices' configuration-done input.

Top module: `cbl_loader`

## Requirements
- R1: The register window sits at these byte offsets: control 0x40, status 0x44, FIFO size 0x48, FIFO fill 0x4C, total bytes 0x50, accepted bytes 0x54, and the write-only data port 0x3000. After reset every register reads zero except FIFO size, which reads DEPTH*4 (64 with defaults). Unmapped offsets read zero.
- R2: While enabled (control bit 0), a word written to the data port is queued. Queued words leave on dn_data_o in write order, one word for each cycle in which dn_valid_o and dn_ready_i are both high.
- R3: A data-port write while enabled and with the FIFO full is dropped. The fill level stays at DEPTH and status bit 1 (overflow) sets.
- R4: The accepted-byte count clears to zero on the control write that takes enable from 0 to 1. It then rises by 4 for each accepted word. No word is offered once the count is at or above the total.
- R5: A write to the total-bytes register while enabled is ignored.
- R6: While enabled, the interrupt rises one cycle after the count reaches the total or any of status bits 15:1 is set. It stays high until a control write with bit 0 clear, and it is low from the cycle after that write.
- R7: While disabled, the FIFO is emptied and data-port writes are ignored, so the fill register reads 0.
- R8: dev_rst_o is high exactly while control bits 0 and 1 are both set. Writing 3 and then 0 produces one reset pulse.
- R9: Status bit 18 follows cfg_done_i. Status bit 2 is a sticky error flag that is set by dev_err_i while the block is enabled.
- R10: dma_req_o is high only when all of these hold: control bit 2 (DMA mode) and enable are set, the interrupt is low, at least DEPTH/2 FIFO words are free, and the accepted bytes plus 4 times the fill level are below the total.
- R11: Once any error bit is set, dn_valid_o stays low until the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 16 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| dn_data_o | output | 32 | Configuration word to the devices |
| dn_valid_o | output | 1 | Word on dn_data_o is valid |
| dn_ready_i | input | 1 | Devices accept the word |
| cfg_done_i | input | 1 | Devices report configuration done |
| dev_err_i | input | 1 | Devices report a configuration error |
| dev_rst_o | output | 1 | Reset to the downstream devices |
| irq_o | output | 1 | Load finished or failed |
| dma_req_o | output | 1 | Request one half-FIFO burst |

## Verification
A register write lands at the clock edge where the strobe is high. The bench reads registers, dev_rst_o, dma_req_o and dn_valid_o on the next falling edge. Read data is combinational from registered state, so it adds no latency. A word offered with ready high is taken at the next rising edge, and the bench records it at the falling edge just before that edge. The interrupt follows its cause by one further edge, so the bench either polls irq_o with a bounded loop or checks it only after at least one extra register read. The interrupt clear is checked on the falling edge right after the disabling write.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
  localparam int unsigned ADDR_W = 16;

  localparam logic [ADDR_W-1:0] A_CTRL  = 16'h0040;
  localparam logic [ADDR_W-1:0] A_STAT  = 16'h0044;
  localparam logic [ADDR_W-1:0] A_FSIZE = 16'h0048;
  localparam logic [ADDR_W-1:0] A_FUSED = 16'h004C;
  localparam logic [ADDR_W-1:0] A_TOTAL = 16'h0050;
  localparam logic [ADDR_W-1:0] A_DONE  = 16'h0054;
  localparam logic [ADDR_W-1:0] A_DATA  = 16'h3000;

  // status bit positions
  localparam int unsigned E_OVF     = 1;
  localparam int unsigned E_DEV     = 2;
  localparam int unsigned S_CFGDONE = 18;

  typedef struct packed {
    logic dma;
    logic rst;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/cbl_fifo.sv
module cbl_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 32,
  parameter int unsigned FW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [FW-1:0] fill_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [FW-1:0] cnt;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wp] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr_i) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_i) wp <= step(wp);
      if (pop_i)  rp <= step(rp);
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign rdata_o = mem[rp];
  assign full_o  = (cnt == FW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign fill_o  = cnt;

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_no_underflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/cbl_dma_pacer.sv
module cbl_dma_pacer #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned FW    = $clog2(DEPTH + 1),
  parameter int unsigned CW    = 32
) (
  input  logic          en_i,
  input  logic          dma_i,
  input  logic          halt_i,
  input  logic [FW-1:0] fill_i,
  input  logic [CW-1:0] done_i,
  input  logic [CW-1:0] total_i,
  output logic          req_o
);
  localparam int unsigned BURST = DEPTH / 2;
  localparam logic [FW-1:0] FILL_MAX = FW'(DEPTH - BURST);

  logic          room;
  logic [CW:0]   queued;

  assign room   = (fill_i <= FILL_MAX);
  // bytes already accepted plus bytes sitting in the FIFO
  assign queued = {1'b0, done_i} + (CW+1)'({fill_i, 2'b00});
  assign req_o  = en_i && dma_i && !halt_i && room && (queued < {1'b0, total_i});
endmodule

// File: rtl/cbl_loader.sv
module cbl_loader
  import cbl_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [31:0]       dn_data_o,
  output logic              dn_valid_o,
  input  logic              dn_ready_i,
  input  logic              cfg_done_i,
  input  logic              dev_err_i,
  output logic              dev_rst_o,
  output logic              irq_o,
  output logic              dma_req_o
);
  localparam int unsigned FW = $clog2(DEPTH + 1);
  localparam int unsigned CW = 32;

  ctrl_t         ctrl_q, ctrl_new;
  logic [CW-1:0] total_q, done_q;
  logic [14:0]   err_q, err_set;
  logic          irq_q;

  logic          wr_ctrl, wr_total, wr_data;
  logic          en_rise, en_drop;
  logic          f_push, f_full, f_empty, ovf;
  logic [FW-1:0] f_fill;
  logic          halt, complete, accept;
  logic [31:0]   stat;

  assign wr_ctrl  = bus_we_i && (bus_addr_i == A_CTRL);
  assign wr_total = bus_we_i && (bus_addr_i == A_TOTAL);
  assign wr_data  = bus_we_i && (bus_addr_i == A_DATA);
  assign ctrl_new = ctrl_t'(bus_wdata_i[2:0]);
  assign en_rise  = wr_ctrl && ctrl_new.en && !ctrl_q.en;
  assign en_drop  = wr_ctrl && !ctrl_new.en;

  assign f_push   = wr_data && ctrl_q.en && !f_full;
  assign ovf      = wr_data && ctrl_q.en && f_full;
  assign halt     = |err_q;
  assign complete = (done_q >= total_q);

  assign dn_valid_o = ctrl_q.en && !f_empty && !complete && !halt;
  assign accept     = dn_valid_o && dn_ready_i;

  always_comb begin
    err_set            = '0;
    err_set[E_OVF - 1] = ovf;
    err_set[E_DEV - 1] = dev_err_i;
  end

  cbl_fifo #(.DEPTH(DEPTH), .W(32), .FW(FW)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!ctrl_q.en),
    .push_i  (f_push),
    .wdata_i (bus_wdata_i),
    .pop_i   (accept),
    .rdata_o (dn_data_o),
    .full_o  (f_full),
    .empty_o (f_empty),
    .fill_o  (f_fill)
  );

  cbl_dma_pacer #(.DEPTH(DEPTH), .FW(FW), .CW(CW)) u_pacer (
    .en_i    (ctrl_q.en),
    .dma_i   (ctrl_q.dma),
    .halt_i  (irq_q),
    .fill_i  (f_fill),
    .done_i  (done_q),
    .total_i (total_q),
    .req_o   (dma_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      total_q <= '0;
      done_q  <= '0;
      err_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_new;
      if (wr_total && !ctrl_q.en) total_q <= bus_wdata_i;
      if (en_rise) begin
        done_q <= '0;
        err_q  <= '0;
      end else if (ctrl_q.en) begin
        if (accept) done_q <= done_q + CW'(4);
        err_q <= err_q | err_set;
      end
      if (en_drop || !ctrl_q.en) irq_q <= 1'b0;
      else if (complete || halt) irq_q <= 1'b1;
    end
  end

  assign irq_o     = irq_q;
  assign dev_rst_o = ctrl_q.en && ctrl_q.rst;

  always_comb begin
    stat            = '0;
    stat[15:1]      = err_q;
    stat[S_CFGDONE] = cfg_done_i;
    case (bus_addr_i)
      A_CTRL:  bus_rdata_o = {29'b0, ctrl_q};
      A_STAT:  bus_rdata_o = stat;
      A_FSIZE: bus_rdata_o = 32'(DEPTH * 4);
      A_FUSED: bus_rdata_o = 32'(f_fill);
      A_TOTAL: bus_rdata_o = total_q;
      A_DONE:  bus_rdata_o = done_q;
      default: bus_rdata_o = '0;
    endcase
  end

  p_irq_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.en |-> !irq_q);
  p_irq_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !wr_ctrl) |=> irq_q);
  p_done_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q != $past(done_q)) |-> (done_q == $past(done_q) + CW'(4) || done_q == '0));
  p_dma_room_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> !f_full);
  p_idle_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.en && !$past(ctrl_q.en)) |-> f_empty);
endmodule

// File: tb/tb_cbl_loader.sv
module tb_cbl_loader;
  import cbl_pkg::*;
  localparam int unsigned DEPTH = 16;

  typedef struct packed {
    logic [31:0] total;
    logic [7:0]  mode;
  } vec_t;
  // total bytes, ready pattern (1 always, 2 alternate, 3 one in four)
  localparam vec_t VECS [3] = '{'{32'd8, 8'd1}, '{32'd40, 8'd2}, '{32'd100, 8'd3}};

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, dn_data;
  logic        dn_valid, dn_ready = 1'b0, cfg_done = 1'b0, dev_err = 1'b0;
  logic        dev_rst, irq, dma_req;

  int          n_chk = 0, n_bad = 0, cyc = 0, rdy_mode = 0, exp_idx = 0;
  logic [31:0] exp_base = '0;
  bit          finished = 1'b0;

  always #4 clk = ~clk; // 8 ns period, 125 MHz

  cbl_loader #(.DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .dn_data_o(dn_data),
    .dn_valid_o(dn_valid), .dn_ready_i(dn_ready), .cfg_done_i(cfg_done),
    .dev_err_i(dev_err), .dev_rst_o(dev_rst), .irq_o(irq), .dma_req_o(dma_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // downstream sink: pick ready, record the word taken at the next rising edge
  initial begin
    forever begin
      bit r;
      @(negedge clk);
      cyc++;
      case (rdy_mode)
        1:       r = 1'b1;
        2:       r = cyc[0];
        3:       r = (cyc % 4 == 0);
        default: r = 1'b0;
      endcase
      dn_ready = r;
      if (dn_valid && r) begin
        chk("R2 stream order", dn_data, exp_base + 32'(exp_idx));
        exp_idx++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state and register offsets
    rd(A_CTRL, v);  chk("R1 ctrl reset", v, 0);
    rd(A_STAT, v);  chk("R1 status reset", v, 0);
    rd(A_FSIZE, v); chk("R1 fifo size", v, DEPTH * 4);
    rd(A_FUSED, v); chk("R1 fill reset", v, 0);
    rd(A_TOTAL, v); chk("R1 total reset", v, 0);
    rd(A_DONE, v);  chk("R1 done reset", v, 0);
    rd(16'h0058, v); chk("R1 unmapped", v, 0);
    chk("R1 irq reset", 32'(irq), 0);
    chk("R1 dma reset", 32'(dma_req), 0);
    chk("R8 dev_rst reset", 32'(dev_rst), 0);

    // table-driven loads in CPU mode
    for (int t = 0; t < 3; t++) begin
      int nw;
      nw = int'(VECS[t].total) / 4;
      wr(A_CTRL, 0);
      wr(A_TOTAL, VECS[t].total);
      exp_base = 32'hC0DE0000 + 32'(t << 8);
      exp_idx = 0;
      rdy_mode = int'(VECS[t].mode);
      wr(A_CTRL, 1);
      for (int i = 0; i < nw; i++) begin
        rd(A_FUSED, v);
        while (v >= DEPTH) rd(A_FUSED, v);
        wr(A_DATA, exp_base + 32'(i));
      end
      for (int k = 0; k < 2000 && !irq; k++) @(negedge clk);
      chk("R6 irq on completion", 32'(irq), 1);
      rd(A_DONE, v); chk("R4 done equals total", v, VECS[t].total);
      chk("R2 word count", 32'(exp_idx), 32'(nw));
      rd(A_STAT, v); chk("R6 no error bits", {16'b0, v[15:1], 1'b0}, 0);
      wr(A_CTRL, 0);
      chk("R6 irq cleared by disable", 32'(irq), 0);
    end
    rdy_mode = 0;

    // R4 re-enable clears the count (total still 100)
    wr(A_CTRL, 1);
    rd(A_DONE, v); chk("R4 done cleared on enable", v, 0);
    chk("R6 no irq while short", 32'(irq), 0);
    wr(A_CTRL, 0);

    // R4 stream stops at total
    wr(A_TOTAL, 4);
    exp_base = 32'h5A5A0000; exp_idx = 0; rdy_mode = 1;
    wr(A_CTRL, 1);
    wr(A_DATA, exp_base);
    wr(A_DATA, exp_base + 1);
    repeat (4) @(negedge clk);
    rd(A_DONE, v);  chk("R4 stops at total", v, 4);
    rd(A_FUSED, v); chk("R4 extra word left queued", v, 1);
    chk("R4 one word taken", 32'(exp_idx), 1);
    chk("R4 valid low at total", 32'(dn_valid), 0);
    rdy_mode = 0;
    wr(A_CTRL, 0);

    // R3 overflow, R11 halt, R5 total locked, R7 idle ignore
    wr(A_TOTAL, 1000);
    wr(A_CTRL, 1);
    for (int i = 0; i < DEPTH + 1; i++) wr(A_DATA, 32'h1000 + 32'(i));
    rd(A_FUSED, v); chk("R3 fill at depth", v, DEPTH);
    rd(A_STAT, v);  chk("R3 overflow bit", 32'(v[1]), 1);
    chk("R6 irq on error", 32'(irq), 1);
    rdy_mode = 1;
    @(negedge clk);
    chk("R11 valid low after error", 32'(dn_valid), 0);
    rdy_mode = 0;
    wr(A_TOTAL, 4);
    rd(A_TOTAL, v); chk("R5 total write ignored", v, 1000);
    wr(A_CTRL, 0);
    chk("R6 irq cleared", 32'(irq), 0);
    wr(A_DATA, 32'hDEAD);
    rd(A_FUSED, v); chk("R7 idle fifo empty", v, 0);

    // R8 downstream reset pulse
    wr(A_CTRL, 3);
    chk("R8 reset high", 32'(dev_rst), 1);
    wr(A_CTRL, 0);
    chk("R8 reset low", 32'(dev_rst), 0);

    // R9 config done and device error
    cfg_done = 1'b1;
    rd(A_STAT, v); chk("R9 cfg done bit", 32'(v[18]), 1);
    cfg_done = 1'b0;
    rd(A_STAT, v); chk("R9 cfg done clear", 32'(v[18]), 0);
    wr(A_TOTAL, 100);
    wr(A_CTRL, 1);
    @(negedge clk); dev_err = 1'b1;
    @(negedge clk); dev_err = 1'b0;
    rd(A_STAT, v); chk("R9 device error sticky", 32'(v[2]), 1);
    chk("R6 irq on device error", 32'(irq), 1);
    wr(A_CTRL, 0);

    // R10 DMA request pacing
    wr(A_TOTAL, 96);
    wr(A_CTRL, 1);
    chk("R10 no request in CPU mode", 32'(dma_req), 0);
    wr(A_CTRL, 0);
    wr(A_CTRL, 5);
    chk("R10 request with room", 32'(dma_req), 1);
    for (int i = 0; i < DEPTH / 2; i++) wr(A_DATA, 32'(i));
    chk("R10 request at half full", 32'(dma_req), 1);
    wr(A_DATA, 32'h99);
    chk("R10 request drops below burst room", 32'(dma_req), 0);
    wr(A_CTRL, 0);
    wr(A_TOTAL, 16);
    wr(A_CTRL, 5);
    for (int i = 0; i < 4; i++) wr(A_DATA, 32'(i));
    chk("R10 request drops once total queued", 32'(dma_req), 0);
    wr(A_CTRL, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule